// File: doc/BRIEF.md
# Accumulator/IO shift-rotate unit

This block performs the shift group of an 18-bit ones' complement machine that keeps two working registers, an accumulator and an IO register. Each cycle it takes a 4-bit sub-operation code, a 9-bit count field and the present values of both registers. It registers the updated accumulator and IO values together with a flag that marks an unknown sub-operation. The datapath of the surrounding processor writes those values back into its own register file.

The shift amount is not a binary number. It is the number of one bits in the count field, so any pattern with three ones moves the data three places. The unit rotates or shifts arithmetically, left or right. It works on the accumulator alone, on IO alone, or on both registers joined into one 36-bit word with the accumulator as the upper half. Arithmetic shifts keep the sign bit of the affected word. Left arithmetic shifts fill the vacated low positions with copies of the sign, which ones' complement needs.

Top module: `shf_unit`

## Requirements
- R1: The shift amount equals the number of one bits in `cnt_i`, from 0 to 9, whatever their positions.
- R2: `op_i` bit 3 selects right (1) or left (0), bit 2 selects arithmetic shift (1) or rotate (0), and bits 1:0 select the target: 1 accumulator, 2 IO, 3 the 36-bit pair. Every code with bits 1:0 nonzero is legal and leaves `bad_o` low.
- R3: A single-register rotate (codes 1, 2, 9, 10) moves the bits circularly within that register, and the other register is unchanged.
- R4: A pair rotate (codes 3, 11) rotates the 36-bit word {AC, IO} circularly. On a left rotate the top accumulator bits enter the low end of IO and the top IO bits enter the low end of the accumulator. A right rotate moves bits the other way.
- R5: A single-register left arithmetic shift (codes 5, 6) keeps bit 17, shifts bits 16:0 left and fills the vacated low bits with the sign. The other register is unchanged.
- R6: A single-register right arithmetic shift (codes 13, 14) shifts right and fills the vacated top bits with the sign. The other register is unchanged.
- R7: A pair left arithmetic shift (code 7) keeps the accumulator sign. Accumulator bits 16:0 shift left and take in the top bits of IO. IO shifts left, and its vacated low bits take copies of the accumulator sign.
- R8: A pair right arithmetic shift (code 15) shifts {AC, IO} right as one 36-bit word. Low accumulator bits move into the top of IO, and the vacated accumulator top bits take copies of the accumulator sign.
- R9: Codes 0, 4, 8 and 12 set `bad_o` and return both registers unchanged.
- R10: A count field of all zeros returns both registers unchanged for every legal code.
- R11: Results appear on the outputs one clock edge after the inputs and stay constant until the next edge. While `rst_n` is low, the outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears the outputs |
| op_i | input | 4 | Sub-operation code |
| cnt_i | input | 9 | Count field; the shift amount is its number of ones |
| ac_i | input | 18 | Present accumulator value |
| io_i | input | 18 | Present IO value |
| ac_o | output | 18 | Updated accumulator value |
| io_o | output | 18 | Updated IO value |
| bad_o | output | 1 | Set for an unknown sub-operation code |

## Verification
In one cycle, the pair arithmetic shifts both copy the accumulator sign into vacated positions and carry bits across the boundary between the two registers. A wrong sign source or a wrong crossing direction therefore shows up only when both happen together. Table vectors with the accumulator sign set, nonzero low bits and counts up to nine provoke this case, and a large random sweep over every code repeats it. A bench model that applies one-bit steps as many times as the count says judges each result, so it shares no shifter structure with the design.

// File: rtl/shf_pkg.sv
package shf_pkg;

    // Fields of the sub-operation code; the target decode depends on them.
    localparam int unsigned OP_W         = 4;
    localparam int unsigned OP_RIGHT_BIT = 3;
    localparam int unsigned OP_ARITH_BIT = 2;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_AC   = 2'd1,
        TGT_IO   = 2'd2,
        TGT_PAIR = 2'd3
    } shf_tgt_e;

endpackage

// File: rtl/shf_popcnt.sv
module shf_popcnt #(
    parameter int unsigned IN_W  = 9,
    parameter int unsigned OUT_W = $clog2(IN_W + 1)
) (
    input  logic [IN_W-1:0]  field_i,
    output logic [OUT_W-1:0] cnt_o
);

    logic [OUT_W-1:0] part [IN_W+1];

    assign part[0] = '0;

    for (genvar g = 0; g < IN_W; g++) begin : g_acc
        assign part[g+1] = part[g] + OUT_W'(field_i[g]);
    end

    assign cnt_o = part[IN_W];

endmodule

// File: rtl/shf_word.sv
module shf_word #(
    parameter int unsigned W     = 18,
    parameter int unsigned AMT_W = 4
) (
    input  logic [W-1:0]     x_i,
    input  logic [AMT_W-1:0] amt_i,
    input  logic             right_i,
    input  logic             arith_i,
    output logic [W-1:0]     y_o
);

    logic             sign;
    logic [2*W-1:0]   rot_l;
    logic [2*W-1:0]   rot_r;
    logic [2*W-2:0]   sal;
    logic [W-1:0]     sar;

    assign sign  = x_i[W-1];
    assign rot_l = {x_i, x_i} << amt_i;
    assign rot_r = {x_i, x_i} >> amt_i;
    assign sal   = {x_i[W-2:0], {W{sign}}} << amt_i;
    assign sar   = W'($signed(x_i) >>> amt_i);

    always_comb begin
        case ({right_i, arith_i})
            2'b00:   y_o = rot_l[2*W-1:W];
            2'b10:   y_o = rot_r[W-1:0];
            2'b01:   y_o = {sign, sal[2*W-2:W]};
            default: y_o = sar;
        endcase
    end

endmodule

// File: rtl/shf_pair.sv
module shf_pair #(
    parameter int unsigned W     = 18,
    parameter int unsigned AMT_W = 4
) (
    input  logic [W-1:0]     ac_i,
    input  logic [W-1:0]     io_i,
    input  logic [AMT_W-1:0] amt_i,
    input  logic             right_i,
    input  logic             arith_i,
    output logic [W-1:0]     ac_o,
    output logic [W-1:0]     io_o
);

    logic             sign;
    logic [4*W-1:0]   rot_l;
    logic [4*W-1:0]   rot_r;
    logic [3*W-2:0]   scl;
    logic [2*W-1:0]   scr;

    assign sign  = ac_i[W-1];
    assign rot_l = {ac_i, io_i, ac_i, io_i} << amt_i;
    assign rot_r = {ac_i, io_i, ac_i, io_i} >> amt_i;
    assign scl   = {ac_i[W-2:0], io_i, {W{sign}}} << amt_i;
    assign scr   = (2*W)'($signed({ac_i, io_i}) >>> amt_i);

    always_comb begin
        case ({right_i, arith_i})
            2'b00:   {ac_o, io_o} = rot_l[4*W-1:2*W];
            2'b10:   {ac_o, io_o} = rot_r[2*W-1:0];
            2'b01: begin
                ac_o = {sign, scl[3*W-2:2*W]};
                io_o = scl[2*W-1:W];
            end
            default: {ac_o, io_o} = scr;
        endcase
    end

endmodule

// File: rtl/shf_unit.sv
module shf_unit
    import shf_pkg::*;
#(
    parameter int unsigned WORD_W = 18,
    parameter int unsigned CNT_W  = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [OP_W-1:0]       op_i,
    input  logic [CNT_W-1:0]      cnt_i,
    input  logic [WORD_W-1:0]     ac_i,
    input  logic [WORD_W-1:0]     io_i,
    output logic [WORD_W-1:0]     ac_o,
    output logic [WORD_W-1:0]     io_o,
    output logic                  bad_o
);

    localparam int unsigned AMT_W = $clog2(CNT_W + 1);

    typedef struct packed {
        logic [WORD_W-1:0] ac;
        logic [WORD_W-1:0] io;
        logic              bad;
    } shf_state_t;

    shf_state_t        st_d, st_q;
    logic [AMT_W-1:0]  amt;
    logic              right_sel;
    logic              arith_sel;
    shf_tgt_e          tgt;
    logic [WORD_W-1:0] w_in  [2];
    logic [WORD_W-1:0] w_out [2];
    logic [WORD_W-1:0] pair_ac, pair_io;

    assign right_sel = op_i[OP_RIGHT_BIT];
    assign arith_sel = op_i[OP_ARITH_BIT];
    assign tgt       = shf_tgt_e'(op_i[1:0]);
    assign w_in[0]   = ac_i;
    assign w_in[1]   = io_i;

    shf_popcnt #(.IN_W(CNT_W), .OUT_W(AMT_W)) u_cnt (
        .field_i (cnt_i),
        .cnt_o   (amt)
    );

    for (genvar g = 0; g < 2; g++) begin : g_word
        shf_word #(.W(WORD_W), .AMT_W(AMT_W)) u_word (
            .x_i     (w_in[g]),
            .amt_i   (amt),
            .right_i (right_sel),
            .arith_i (arith_sel),
            .y_o     (w_out[g])
        );
    end

    shf_pair #(.W(WORD_W), .AMT_W(AMT_W)) u_pair (
        .ac_i    (ac_i),
        .io_i    (io_i),
        .amt_i   (amt),
        .right_i (right_sel),
        .arith_i (arith_sel),
        .ac_o    (pair_ac),
        .io_o    (pair_io)
    );

    always_comb begin
        st_d.ac  = ac_i;
        st_d.io  = io_i;
        st_d.bad = 1'b0;
        case (tgt)
            TGT_NONE: st_d.bad = 1'b1;
            TGT_AC:   st_d.ac  = w_out[0];
            TGT_IO:   st_d.io  = w_out[1];
            TGT_PAIR: begin
                st_d.ac = pair_ac;
                st_d.io = pair_io;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ac_o  = st_q.ac;
    assign io_o  = st_q.io;
    assign bad_o = st_q.bad;

endmodule

// File: rtl/shf_unit_chk.sv
module shf_unit_chk #(
    parameter int unsigned WORD_W = 18,
    parameter int unsigned CNT_W  = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        op_i,
    input logic [CNT_W-1:0]  cnt_i,
    input logic [WORD_W-1:0] ac_i,
    input logic [WORD_W-1:0] io_i,
    input logic [WORD_W-1:0] ac_o,
    input logic [WORD_W-1:0] io_o,
    input logic              bad_o
);

    // R9
    illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i[1:0] == 2'b00) |=> (bad_o && ac_o == $past(ac_i) && io_o == $past(io_i)));

    // R2
    legal_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i[1:0] != 2'b00) |=> !bad_o);

    // R10
    zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_i == '0) |=> (ac_o == $past(ac_i) && io_o == $past(io_i)));

    // R3
    ac_rotate_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_i[2] && op_i[1:0] == 2'b01) |=>
        ($countones(ac_o) == $countones($past(ac_i)) && io_o == $past(io_i)));

    // R4
    pair_rotate_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_i[2] && op_i[1:0] == 2'b11) |=>
        ($countones({ac_o, io_o}) == $countones($past({ac_i, io_i}))));

    // R5
    ac_sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i[2] && op_i[0]) |=> (ac_o[WORD_W-1] == $past(ac_i[WORD_W-1])));

    // R6
    io_sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i[2] && op_i[1:0] == 2'b10) |=>
        (io_o[WORD_W-1] == $past(io_i[WORD_W-1]) && ac_o == $past(ac_i)));

endmodule

bind shf_unit shf_unit_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .op_i  (op_i),
    .cnt_i (cnt_i),
    .ac_i  (ac_i),
    .io_i  (io_i),
    .ac_o  (ac_o),
    .io_o  (io_o),
    .bad_o (bad_o)
);

// File: tb/sim_shf_unit.sv
module sim_shf_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op = '0;
    logic [8:0]  cnt = '0;
    logic [17:0] ac = '0;
    logic [17:0] io = '0;
    logic [17:0] ac_o, io_o;
    logic        bad_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    shf_unit u0 (
        .clk   (clk),
        .rst_n (rst_n),
        .op_i  (op),
        .cnt_i (cnt),
        .ac_i  (ac),
        .io_i  (io),
        .ac_o  (ac_o),
        .io_o  (io_o),
        .bad_o (bad_o)
    );

    typedef struct packed {
        logic [3:0]  op;
        logic [8:0]  cnt;
        logic [17:0] ac;
        logic [17:0] io;
        logic [17:0] eac;
        logic [17:0] eio;
        logic        ebad;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t TBL [NV] = '{
        '{4'd1,  9'o001, 18'o400001, 18'o123456, 18'o000003, 18'o123456, 1'b0}, // R3 R1
        '{4'd5,  9'o007, 18'o600001, 18'o000000, 18'o400017, 18'o000000, 1'b0}, // R5
        '{4'd13, 9'o401, 18'o400100, 18'o000000, 18'o700020, 18'o000000, 1'b0}, // R6 R1
        '{4'd11, 9'o002, 18'o000001, 18'o000000, 18'o000000, 18'o400000, 1'b0}, // R4
        '{4'd7,  9'o200, 18'o400000, 18'o400000, 18'o400001, 18'o000001, 1'b0}, // R7
        '{4'd15, 9'o017, 18'o400017, 18'o000000, 18'o760000, 18'o740000, 1'b0}, // R8
        '{4'd4,  9'o777, 18'o123456, 18'o654321, 18'o123456, 18'o654321, 1'b1}, // R9
        '{4'd2,  9'o000, 18'o000000, 18'o654321, 18'o000000, 18'o654321, 1'b0}, // R10
        '{4'd14, 9'o777, 18'o000000, 18'o400000, 18'o000000, 18'o777400, 1'b0}, // R6 R1
        '{4'd6,  9'o400, 18'o111111, 18'o000001, 18'o111111, 18'o000002, 1'b0}, // R5
        '{4'd10, 9'o001, 18'o000000, 18'o000001, 18'o000000, 18'o400000, 1'b0}, // R3
        '{4'd3,  9'o003, 18'o600000, 18'o000000, 18'o000000, 18'o000003, 1'b0}, // R4
        '{4'd9,  9'o010, 18'o000001, 18'o000000, 18'o400000, 18'o000000, 1'b0}  // R3 R2
    };

    string tags [NV] = '{"R3", "R5", "R6", "R4", "R7", "R8", "R9",
                         "R10", "R6", "R5", "R3", "R4", "R2"};

    // Model built from the requirements: one-bit steps, repeated.
    function automatic void model(input logic [3:0] o, input logic [8:0] c,
                                  input logic [17:0] a_in, input logic [17:0] i_in,
                                  output logic [17:0] a, output logic [17:0] i,
                                  output logic b);
        int n = 0;
        a = a_in;
        i = i_in;
        b = (o[1:0] == 2'b00);
        for (int k = 0; k < 9; k++) if (c[k]) n++;
        if (!b) begin
            for (int s = 0; s < n; s++) begin
                case (o)
                    4'd1:  a = {a[16:0], a[17]};
                    4'd2:  i = {i[16:0], i[17]};
                    4'd3:  {a, i} = {a[16:0], i[17], i[16:0], a[17]};
                    4'd5:  a = {a[17], a[15:0], a[17]};
                    4'd6:  i = {i[17], i[15:0], i[17]};
                    4'd7:  {a, i} = {a[17], a[15:0], i[17], i[16:0], a[17]};
                    4'd9:  a = {a[0], a[17:1]};
                    4'd10: i = {i[0], i[17:1]};
                    4'd11: {a, i} = {i[0], a[17:1], a[0], i[17:1]};
                    4'd13: a = {a[17], a[17:1]};
                    4'd14: i = {i[17], i[17:1]};
                    default: {a, i} = {a[17], a[17:1], a[0], i[17:1]};
                endcase
            end
        end
    endfunction

    task automatic check(input string tag, input logic [36:0] got, input logic [36:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual ac=%o io=%o bad=%b expected ac=%o io=%o bad=%b",
                     tag, got[36:19], got[18:1], got[0], exp[36:19], exp[18:1], exp[0]);
        end
    endtask

    task automatic apply(input logic [3:0] o, input logic [8:0] c,
                         input logic [17:0] a, input logic [17:0] i);
        @(negedge clk);
        op  = o;
        cnt = c;
        ac  = a;
        io  = i;
        @(negedge clk);
    endtask

    initial begin
        logic [17:0] ea, ei;
        logic        eb;

        // R11 reset state
        repeat (3) @(negedge clk);
        check("R11 reset", {ac_o, io_o, bad_o}, 37'd0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            apply(TBL[v].op, TBL[v].cnt, TBL[v].ac, TBL[v].io);
            check(tags[v], {ac_o, io_o, bad_o}, {TBL[v].eac, TBL[v].eio, TBL[v].ebad});
        end

        // R11 outputs hold until the next edge
        @(negedge clk);
        op = 4'd1; cnt = 9'o001; ac = 18'o000001; io = 18'o000000;
        #1;
        check("R11 hold", {ac_o, io_o, bad_o}, {18'o400000, 18'o000000, 1'b0});
        @(negedge clk);
        check("R11 latency", {ac_o, io_o, bad_o}, {18'o000002, 18'o000000, 1'b0});

        // R10 zero count on every legal code; R9 every illegal code
        for (int o = 0; o < 16; o++) begin
            apply(4'(o), 9'o000, 18'o543210, 18'o012345);
            if (o % 4 == 0)
                check("R9 illegal", {ac_o, io_o, bad_o}, {18'o543210, 18'o012345, 1'b1});
            else
                check("R10 zero count", {ac_o, io_o, bad_o}, {18'o543210, 18'o012345, 1'b0});
        end

        // R1 same count from scattered patterns
        apply(4'd15, 9'o421, 18'o400017, 18'o000000);
        check("R1 scattered", {ac_o, io_o, bad_o}, {18'o740001, 18'o700000, 1'b0});

        // Sweep: R1 R2 R3 R4 R5 R6 R7 R8 R9 against the stepwise model
        for (int r = 0; r < 1600; r++) begin
            logic [3:0]  o;
            logic [8:0]  c;
            logic [17:0] a, i;
            o = 4'(r % 16);
            c = 9'($urandom);
            a = 18'($urandom);
            i = 18'($urandom);
            if (r % 3 == 0) a[17] = 1'b1;
            model(o, c, a, i, ea, ei, eb);
            apply(o, c, a, i);
            check("R1-model R2 R3 R4 R5 R6 R7 R8 R9", {ac_o, io_o, bad_o}, {ea, ei, eb});
        end

        // R11 reset mid-run clears outputs
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R11 reset mid-run", {ac_o, io_o, bad_o}, 37'd0);
        rst_n = 1'b1;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule